// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus-master addresses that fall inside a graphics aperture onto physical page addresses. It does this by walking a two-level table that software keeps in system memory. The first level is a directory of 1024 32-bit words. Each valid word points at a 4 KiB page table of 1024 words, and each valid table word points at a 4 KiB physical page. The low 12 address bits are carried through unchanged. Addresses outside the aperture are returned as they arrive. A small fully associative cache of recent translations lets repeated accesses to a page skip the table walk.

Software programs the directory base and a cache-control byte through a small register port. It invalidates cached translations with two flush commands, issued in order: a post flush, then a directory flush. Each flush register reads 1 while its flush is running. Software normally points unused directory slots at a scratch table, and unused table words at one scratch page. Accesses to unmapped pages then land on that page with no error. The translator only follows the pointers it reads, so this redirection needs no special logic.

Top module: `gart_xlate`

## Requirements
- R1: After reset, rsp_valid and mem_rd are 0, req_ready is 1, and the directory base (offset 0x04) and both flush registers (offsets 0x0C, 0x14) read 0.
- R2: A request whose address differs from aper_base in any bit at position aper_log2 or above is outside the aperture. It is returned unchanged with rsp_err=0, with rsp_valid high in the cycle after the request is accepted, and it causes no memory read.
- R3: On a cache miss inside the aperture, the block makes two single reads. The first is the directory word at dirbase + 4*(addr[31:22] - aper_base[31:22]) (10-bit difference). The second is the table word at {dir[31:12], addr[21:12], 2'b00}. The result is {tbl[31:12], addr[11:0]} with rsp_err=0.
- R4: A directory or table word with bit 0 clear gives rsp_err=1 and rsp_addr=0. When the directory word is invalid, no table read is made.
- R5: A request to a page whose translation is cached responds in the cycle after acceptance with no memory read. Error results are not cached.
- R6: Offset 0x04 is a 32-bit read/write directory base. Offset 0x02 is an 8-bit read/write cache-control register whose upper 24 read bits are 0.
- R7: Writing a value with bit 0 set to offset 0x14 starts a post flush. The register reads 1 for at least FLUSH_CYC cycles, and never while a table walk is in progress, then reads 0. The flush empties the translation cache.
- R8: Writing a value with bit 0 set to offset 0x0C starts a directory flush with the same busy rule and cache clearing. The write is ignored while a post flush is busy.
- R9: req_ready is 0 while any flush is busy and while a response is pending. A response holds rsp_addr and rsp_err stable until rsp_ready is 1.
- R10: The aperture covers 2^aper_log2 bytes, with aper_log2 from 25 (32 MiB) to 31 (2 GiB).
- R11: The cache holds TLB_ENTRIES translations and replaces them in round-robin order of filling. With 4 entries, the fifth new page evicts the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aper_base | input | 32 | Aperture base address, aligned to its size |
| aper_log2 | input | 5 | log2 of the aperture size in bytes |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted |
| req_addr | input | 32 | Address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Result consumed |
| rsp_addr | output | 32 | Translated address |
| rsp_err | output | 1 | Table entry invalid |
| mem_rd | output | 1 | One-cycle read request for a table word |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Pass-through and cache-hit results are due one cycle after the accepting edge. Miss results are due after two memory round trips, or one when the directory word is invalid. The bench counts cycles from acceptance and requires latency 1 when no memory read occurs. It also counts memory reads per request, which separates hits from misses. Flush busy time is measured by reading the flush register on every cycle after the write. Register reads are combinational and are sampled at the falling edge after the address is set.

// File: rtl/gart_pkg.sv
package gart_pkg;
  localparam int ADDR_W  = 32;
  localparam int PG_BITS = 12;
  localparam int IDX_W   = 10;
  localparam int PN_W    = ADDR_W - PG_BITS;

  localparam logic [7:0] OFF_CTL  = 8'h02;
  localparam logic [7:0] OFF_DIRB = 8'h04;
  localparam logic [7:0] OFF_DFL  = 8'h0C;
  localparam logic [7:0] OFF_PFL  = 8'h14;

  typedef enum logic [2:0] {
    W_IDLE, W_DREQ, W_DWAIT, W_TREQ, W_TWAIT, W_RESP
  } walk_st_e;
endpackage

// File: rtl/gart_regs.sv
module gart_regs
  import gart_pkg::*;
#(
  parameter int FLUSH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        addr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              walk_busy,
  output logic [ADDR_W-1:0] rdata,
  output logic [ADDR_W-1:0] dir_base,
  output logic              flush_busy,
  output logic              flush_clr
);
  localparam int CW = $clog2(FLUSH_CYC + 1);

  logic [7:0]        ctl_q, ctl_d;
  logic [ADDR_W-1:0] dirb_q, dirb_d;
  logic [1:0]        busy_q, busy_d, start;
  logic [CW-1:0]     cnt_q [2];
  logic [CW-1:0]     cnt_d [2];

  // index 0: post flush, index 1: directory flush (ordered after post)
  assign start[0] = wr && addr == OFF_PFL && wdata[0] && !busy_q[0];
  assign start[1] = wr && addr == OFF_DFL && wdata[0] && !busy_q[0] && !busy_q[1];

  generate
    for (genvar g = 0; g < 2; g++) begin : g_flush
      always_comb begin
        busy_d[g] = busy_q[g];
        cnt_d[g]  = cnt_q[g];
        if (start[g]) begin
          busy_d[g] = 1'b1;
          cnt_d[g]  = '0;
        end else if (busy_q[g]) begin
          if (cnt_q[g] < CW'(FLUSH_CYC)) cnt_d[g] = cnt_q[g] + 1'b1;
          if (cnt_q[g] >= CW'(FLUSH_CYC - 1) && !walk_busy) busy_d[g] = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busy_q[g] <= 1'b0;
          cnt_q[g]  <= '0;
        end else begin
          busy_q[g] <= busy_d[g];
          cnt_q[g]  <= cnt_d[g];
        end
      end
    end
  endgenerate

  always_comb begin
    ctl_d  = ctl_q;
    dirb_d = dirb_q;
    if (wr && addr == OFF_CTL)  ctl_d  = wdata[7:0];
    if (wr && addr == OFF_DIRB) dirb_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      dirb_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      dirb_q <= dirb_d;
    end
  end

  always_comb begin
    case (addr)
      OFF_CTL:  rdata = {24'h0, ctl_q};
      OFF_DIRB: rdata = dirb_q;
      OFF_DFL:  rdata = {31'h0, busy_q[1]};
      OFF_PFL:  rdata = {31'h0, busy_q[0]};
      default:  rdata = '0;
    endcase
  end

  assign dir_base   = dirb_q;
  assign flush_busy = |busy_q;
  assign flush_clr  = |start;

  // R7
  post_busy_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q[0] && walk_busy |=> busy_q[0]);
  // R8
  dir_after_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q[1]) |-> !$past(busy_q[0]));
endmodule

// File: rtl/gart_tlb.sv
module gart_tlb
  import gart_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [PN_W-1:0] lk_tag,
  input  logic            fill,
  input  logic [PN_W-1:0] fill_tag,
  input  logic [PN_W-1:0] fill_ppn,
  output logic            hit,
  output logic [PN_W-1:0] hit_ppn
);
  localparam int VW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec;
  logic [VW-1:0]      vic_q, vic_d;
  logic [PN_W-1:0]    tag_q [ENTRIES];
  logic [PN_W-1:0]    ppn_q [ENTRIES];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
      always_ff @(posedge clk) begin
        if (fill && vic_q == VW'(g)) begin
          tag_q[g] <= fill_tag;
          ppn_q[g] <= fill_ppn;
        end
      end
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | ppn_q[i];
  end
  assign hit = |hit_vec;

  always_comb begin
    vld_d = vld_q;
    vic_d = vic_q;
    if (clr) begin
      vld_d = '0;
    end else if (fill) begin
      vld_d[vic_q] = 1'b1;
      vic_d = (vic_q == VW'(ENTRIES - 1)) ? '0 : vic_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      vic_q <= '0;
    end else begin
      vld_q <= vld_d;
      vic_q <= vic_d;
    end
  end

  // R5
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R7
  no_fill_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !fill);
endmodule

// File: rtl/gart_walk.sv
module gart_walk
  import gart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] aper_base,
  input  logic [4:0]        aper_log2,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              flush_busy,
  input  logic              flush_clr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_err,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              tlb_hit,
  input  logic [PN_W-1:0]   tlb_ppn,
  output logic              tlb_fill,
  output logic [PN_W-1:0]   tlb_fill_tag,
  output logic              walk_busy
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] va_q, va_d, res_q, res_d;
  logic [PN_W-1:0]   tp_q, tp_d;
  logic              err_q, err_d, stale_q, stale_d;
  logic              accept, in_aper;
  logic [IDX_W-1:0]  dir_idx;

  assign in_aper   = ((req_addr ^ aper_base) >> aper_log2) == '0;
  assign req_ready = (st_q == W_IDLE) && !flush_busy;
  assign accept    = req_valid && req_ready;
  assign dir_idx   = va_q[31:22] - aper_base[31:22];
  assign mem_rd    = (st_q == W_DREQ) || (st_q == W_TREQ);
  assign mem_addr  = (st_q == W_TREQ) ? {tp_q, va_q[21:12], 2'b00}
                                      : {dir_base[31:12], 12'h0} + {20'h0, dir_idx, 2'b00};
  assign rsp_valid = (st_q == W_RESP);
  assign rsp_addr  = res_q;
  assign rsp_err   = err_q;
  assign walk_busy = (st_q != W_IDLE) && (st_q != W_RESP);
  assign tlb_fill_tag = va_q[31:12];
  assign tlb_fill  = (st_q == W_TWAIT) && mem_rvalid && mem_rdata[0] && !stale_q && !flush_clr;

  always_comb begin
    st_d = st_q; va_d = va_q; res_d = res_q; tp_d = tp_q; err_d = err_q;
    stale_d = stale_q || flush_clr;
    case (st_q)
      W_IDLE: if (accept) begin
        va_d = req_addr; stale_d = 1'b0; err_d = 1'b0;
        if (!in_aper) begin
          res_d = req_addr; st_d = W_RESP;
        end else if (tlb_hit) begin
          res_d = {tlb_ppn, req_addr[11:0]}; st_d = W_RESP;
        end else begin
          st_d = W_DREQ;
        end
      end
      W_DREQ: st_d = W_DWAIT;
      W_DWAIT: if (mem_rvalid) begin
        if (!mem_rdata[0]) begin
          err_d = 1'b1; res_d = '0; st_d = W_RESP;
        end else begin
          tp_d = mem_rdata[31:12]; st_d = W_TREQ;
        end
      end
      W_TREQ: st_d = W_TWAIT;
      W_TWAIT: if (mem_rvalid) begin
        st_d = W_RESP;
        if (!mem_rdata[0]) begin
          err_d = 1'b1; res_d = '0;
        end else begin
          res_d = {mem_rdata[31:12], va_q[11:0]};
        end
      end
      W_RESP: if (rsp_ready) st_d = W_IDLE;
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; va_q <= '0; res_q <= '0; tp_q <= '0;
      err_q <= 1'b0; stale_q <= 1'b0;
    end else begin
      st_q <= st_d; va_q <= va_d; res_q <= res_d; tp_q <= tp_d;
      err_q <= err_d; stale_q <= stale_d;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_err));
  // R9
  flush_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready);
  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R4
  err_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_addr == '0);
endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
  import gart_pkg::*;
#(
  parameter int TLB_ENTRIES = 4,
  parameter int FLUSH_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] aper_base,
  input  logic [4:0]  aper_log2,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_addr,
  output logic        rsp_err,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [ADDR_W-1:0] dir_base;
  logic              flush_busy, flush_clr, walk_busy;
  logic              tlb_hit, tlb_fill;
  logic [PN_W-1:0]   tlb_ppn, tlb_fill_tag;

  gart_regs #(.FLUSH_CYC(FLUSH_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .walk_busy(walk_busy), .rdata(reg_rdata), .dir_base(dir_base),
    .flush_busy(flush_busy), .flush_clr(flush_clr)
  );

  gart_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n), .clr(flush_clr), .lk_tag(req_addr[31:12]),
    .fill(tlb_fill), .fill_tag(tlb_fill_tag), .fill_ppn(mem_rdata[31:12]),
    .hit(tlb_hit), .hit_ppn(tlb_ppn)
  );

  gart_walk u_walk (
    .clk(clk), .rst_n(rst_n), .aper_base(aper_base), .aper_log2(aper_log2),
    .dir_base(dir_base), .flush_busy(flush_busy), .flush_clr(flush_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_err(rsp_err), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_fill(tlb_fill), .tlb_fill_tag(tlb_fill_tag),
    .walk_busy(walk_busy)
  );
endmodule

// File: tb/gart_xlate_test.sv
`timescale 1ns/1ps
module gart_xlate_test;
  localparam int FLUSH_CYC = 4;
  localparam int NV = 12;

  logic        clk = 0, rst_n = 0;
  logic [31:0] aper_base = 32'h8000_0000;
  logic [4:0]  aper_log2 = 5'd25;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_err;
  logic [31:0] req_addr = 0, rsp_addr;
  logic        mem_rd, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  int nreads = 0, checks = 0, errors = 0;

  gart_xlate #(.TLB_ENTRIES(4), .FLUSH_CYC(FLUSH_CYC)) uut (.*);

  always #10 clk = ~clk;

  // table image: dir at 0x0010_0000, tables at 0x0020_x000, scratch table 0x0030_0000, scratch page 0x0050_0000
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int unsigned j;
    j = a[11:2];
    if (a[31:12] == 20'h00100) begin
      if (j < 4) return 32'h0020_0001 + (j << 12);
      if (j == 5) return 32'h0;
      return 32'h0030_0001;
    end
    if (a[31:16] == 16'h0020) begin
      if (j == 7) return 32'h0;
      return 32'h4000_0001 + ((a[15:12] * 1024 + j) << 12);
    end
    if (a[31:12] == 20'h00300) return 32'h0050_0001;
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem_word(mem_addr);
      nreads     <= nreads + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic do_req(input logic [31:0] a, output logic [31:0] ra, output logic re,
                        output int lat, output int rd);
    int r0;
    @(negedge clk); req_addr = a; req_valid = 1; rsp_ready = 1;
    while (!req_ready) @(negedge clk);
    r0 = nreads;
    @(negedge clk); req_valid = 0; lat = 1;
    while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
    ra = rsp_addr; re = rsp_err; rd = nreads - r0;
  endtask

  localparam logic [31:0] V_IN [NV] = '{
    32'h1234_5678, 32'h8000_0ABC, 32'h8000_0DEF, 32'h8040_3010,
    32'h8000_7004, 32'h8140_0020, 32'h8180_2100, 32'h8200_0000,
    32'h81FF_FFFF, 32'h8000_1000, 32'h8000_0000, 32'h8180_2FFF};
  localparam logic [31:0] V_OUT [NV] = '{
    32'h1234_5678, 32'h4000_0ABC, 32'h4000_0DEF, 32'h4040_3010,
    32'h0000_0000, 32'h0000_0000, 32'h0050_0100, 32'h8200_0000,
    32'h0050_0FFF, 32'h4000_1000, 32'h4000_0000, 32'h0050_0FFF};
  localparam logic V_ERR [NV] = '{0,0,0,0,1,1,0,0,0,0,0,0};
  localparam int   V_RD  [NV] = '{0,2,0,2,2,1,2,0,2,2,2,0};
  // requirement covered by each vector
  localparam string V_TAG [NV] = '{"R2","R3","R5","R3","R4","R4","R3","R10",
                                   "R10","R11","R11","R5"};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, ra, ra2;
    logic re, re2;
    int lat, rd, cnt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0 && mem_rd == 0, "R1 outputs idle", {rsp_valid, mem_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    rd_now(8'h04, d); chk(d == 0, "R1 dirbase", d, 0);
    rd_now(8'h14, d); chk(d == 0, "R1 post flush", d, 0);
    rd_now(8'h0C, d); chk(d == 0, "R1 dir flush", d, 0);

    // R6 registers
    wr_reg(8'h04, 32'h0010_0000); rd_now(8'h04, d); chk(d == 32'h0010_0000, "R6 dirbase", d, 32'h0010_0000);
    wr_reg(8'h02, 32'h0000_01FF); rd_now(8'h02, d); chk(d == 32'h0000_00FF, "R6 ctl width", d, 32'hFF);
    wr_reg(8'h02, 32'h0000_000A); rd_now(8'h02, d); chk(d == 32'h0000_000A, "R6 ctl", d, 32'h0A);

    for (int i = 0; i < NV; i++) begin
      do_req(V_IN[i], ra, re, lat, rd);
      chk(ra == V_OUT[i] && re == V_ERR[i], {V_TAG[i], " result"}, ra, V_OUT[i]);
      chk(rd == V_RD[i], {V_TAG[i], " reads"}, rd, V_RD[i]);
      if (V_RD[i] == 0) chk(lat == 1, {V_TAG[i], " latency"}, lat, 1);
    end

    // R8 directory flush ignored while post flush busy; R9 ready low
    wr_reg(8'h14, 1);
    chk(req_ready == 0, "R9 ready during flush", req_ready, 0);
    wr_reg(8'h0C, 1);
    rd_now(8'h0C, d); chk(d == 0, "R8 ignored during post", d, 0);
    cnt = 0; rd_now(8'h14, d);
    while (d[0] && cnt < 50) begin @(negedge clk); cnt++; rd_now(8'h14, d); end
    chk(d == 0, "R7 post flush done", d, 0);

    // R7 busy length and cache clear
    wr_reg(8'h14, 1);
    cnt = 0; rd_now(8'h14, d);
    while (d[0] && cnt < 50) begin cnt++; @(negedge clk); rd_now(8'h14, d); end
    chk(cnt >= FLUSH_CYC && cnt <= FLUSH_CYC + 1, "R7 busy cycles", cnt, FLUSH_CYC);
    do_req(32'h8000_0000, ra, re, lat, rd);
    chk(rd == 2 && ra == 32'h4000_0000, "R7 cache cleared", rd, 2);

    // R8 directory flush
    wr_reg(8'h0C, 1);
    cnt = 0; rd_now(8'h0C, d);
    while (d[0] && cnt < 50) begin cnt++; @(negedge clk); rd_now(8'h0C, d); end
    chk(cnt >= FLUSH_CYC && cnt <= FLUSH_CYC + 1, "R8 busy cycles", cnt, FLUSH_CYC);
    do_req(32'h8000_0000, ra, re, lat, rd);
    chk(rd == 2, "R8 cache cleared", rd, 2);

    // R9 response hold under backpressure (hit)
    @(negedge clk); req_addr = 32'h8000_0004; req_valid = 1; rsp_ready = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    chk(rsp_valid == 1, "R9 hit response", rsp_valid, 1);
    ra = rsp_addr; re = rsp_err;
    repeat (3) @(negedge clk);
    ra2 = rsp_addr; re2 = rsp_err;
    chk(rsp_valid && ra2 == ra && re2 == re && ra == 32'h4000_0004, "R9 hold", ra2, 32'h4000_0004);
    chk(req_ready == 0, "R9 ready while pending", req_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9 consumed", rsp_valid, 0);

    // R10 larger aperture brings 0x8200_0000 inside (dir slot 8 -> scratch)
    aper_log2 = 5'd26;
    do_req(32'h8200_0000, ra, re, lat, rd);
    chk(ra == 32'h0050_0000 && re == 0 && rd == 2, "R10 64MiB aperture", ra, 32'h0050_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule